// File: doc/BRIEF.md
# Scrambled Super-Pixel Frame Builder

The block gathers super-pixel packets of 30 bits each and places four of them in a 128-bit frame for a high-speed serializer. Each frame starts with an 8-bit header. Its upper nibble is a fixed sync value, and its lower nibble holds one even-parity bit per packet slot, taken over the unscrambled packet bits. The 120 payload bits that follow are XORed with the output of a free-running additive scrambler. This prevents long runs of equal bits on the line. The header is never scrambled.

The frame leaves the block one byte per clock, most significant byte first, with the header byte first. A start flag marks that first byte. Frames are sent back to back: every 16 clocks a new frame goes out, whether or not any packets are waiting. Packets arrive on a valid/ready stream. When fewer than four packets have arrived by the time a frame has to be launched, the unused slots carry the all-zero packet. Its hitmap is zero, so a receiver reads it as empty.

Top module: `sp_frame_packer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `out_sof` and `out_byte` are 0. Reset seeds the scrambler state to all ones (7'h7F).
- R2: A frame is launched at the first clock edge after reset and then every 16 clocks. `out_sof` is 1 only on the header byte, and `out_valid` stays 1 from the first header byte onward.
- R3: Header bits [7:4] are 4'h5 and go out unscrambled.
- R4: Header bit k (k = 0..3, bit 0 the least significant) is the XOR of all 30 bits of slot k before scrambling. Slot 0 holds the oldest packet of the frame.
- R5: Before scrambling, the 120 payload bits are slot 0 in bits [119:90], slot 1 in [89:60], slot 2 in [59:30] and slot 3 in [29:0]. Payload bit 119 is the MSB of the second byte. Packets fill the slots in arrival order.
- R6: Each payload byte is XORed with 8 keystream bits, MSB first. Each keystream bit is s[6]^s[5] of the 7-bit state, which then shifts left with that bit entering at s[0] (polynomial x^7+x^6+1). The state advances 8 steps per payload byte, does not advance on header bytes, and carries over from frame to frame.
- R7: A slot with no packet is sent as 30 zero bits before scrambling, and its parity bit is 0.
- R8: `in_ready` is 0 while four packets are held and no launch is taking place. A packet is taken only when `in_valid` and `in_ready` are both 1, and an offer that is not taken does not appear in any frame.
- R9: A packet taken in the launch cycle (the edge that loads a new header) is not in that frame. It becomes slot 0 of the next frame, and `in_ready` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet offered |
| in_data | input | 30 | Super-pixel packet |
| in_ready | output | 1 | Packet can be taken this cycle |
| out_byte | output | 8 | Frame byte to the serializer |
| out_sof | output | 1 | Marks the header byte of a frame |
| out_valid | output | 1 | Byte stream running |

## Verification
A packet taken at an edge goes into the frame loaded at the next launch edge. The header byte of that frame appears on the outputs right after the launch edge, and payload byte n appears n edges later. The bench reference model steps once per clock on the falling edge. It takes the offer that is about to be sampled, predicts `in_ready` directly, and predicts the registered byte, flag and valid values that will follow the coming edge. It compares these on the next falling edge, so every output is checked one cycle after the stimulus that caused it.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int          SYNC_W    = 4;
  localparam logic [3:0]  SYNC_VAL  = 4'h5;
  localparam int          SCR_W     = 7;
  localparam int          SCR_TAP_A = 6;
  localparam int          SCR_TAP_B = 5;
  localparam logic [6:0]  SCR_SEED  = 7'h7F;
endpackage

// File: rtl/spf_slot_collector.sv
module spf_slot_collector #(
  parameter int PKT_W = 30,
  parameter int SLOTS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   launch,
  input  logic                   in_valid,
  input  logic [PKT_W-1:0]       in_data,
  output logic                   in_ready,
  output logic [SLOTS*PKT_W-1:0] slots_flat
);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [PKT_W-1:0] slot_q [SLOTS];
  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign in_ready = (cnt_q < CNT_W'(SLOTS)) || launch;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (launch) begin
      cnt_q <= take ? CNT_W'(1) : '0;
    end else if (take) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      if (launch) slot_q[0] <= in_data;
      else        slot_q[cnt_q[IDX_W-1:0]] <= in_data;
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot_out
    assign slots_flat[(SLOTS-1-k)*PKT_W +: PKT_W] =
      (cnt_q > CNT_W'(k)) ? slot_q[k] : '0;
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(SLOTS));
  p_refill_after_launch_r9: assert property (@(posedge clk) disable iff (rst)
    launch |=> (cnt_q <= CNT_W'(1)));
  p_hold_when_full_r8: assert property (@(posedge clk) disable iff (rst)
    (!launch && !in_ready) |=> $stable(cnt_q));
endmodule

// File: rtl/spf_frame_assembler.sv
module spf_frame_assembler
  import spf_pkg::*;
#(
  parameter int PKT_W = 30,
  parameter int SLOTS = 4
) (
  input  logic [SLOTS*PKT_W-1:0]              slots_flat,
  output logic [SYNC_W+SLOTS+SLOTS*PKT_W-1:0] frame
);
  localparam int PAY_W = SLOTS * PKT_W;

  logic [SLOTS-1:0] par;

  for (genvar k = 0; k < SLOTS; k++) begin : g_par
    assign par[k] = ^slots_flat[(SLOTS-1-k)*PKT_W +: PKT_W];
  end

  assign frame = {SYNC_VAL, par, slots_flat[PAY_W-1:0]};
endmodule

// File: rtl/spf_byte_serializer.sv
module spf_byte_serializer
  import spf_pkg::*;
#(
  parameter int FRAME_W = 128,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               launch,
  output logic [BYTE_W-1:0]  out_byte,
  output logic               out_sof,
  output logic               out_valid
);
  localparam int PAY_W  = FRAME_W - BYTE_W;
  localparam int NBYTES = FRAME_W / BYTE_W;
  localparam int BC_W   = $clog2(NBYTES);
  localparam logic [BC_W-1:0] LAST = BC_W'(NBYTES - 1);

  logic [BC_W-1:0]  bcnt_q;
  logic [PAY_W-1:0] pay_q;
  logic [SCR_W-1:0] scr_q, scr_nx;
  logic [BYTE_W-1:0] ks;

  assign launch = (bcnt_q == LAST);

  always_comb begin
    logic [SCR_W-1:0] s;
    logic fb;
    s  = scr_q;
    ks = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb    = s[SCR_TAP_A] ^ s[SCR_TAP_B];
      ks[i] = fb;
      s     = {s[SCR_W-2:0], fb};
    end
    scr_nx = s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt_q    <= LAST;
      scr_q     <= SCR_SEED;
      out_byte  <= '0;
      out_sof   <= 1'b0;
      out_valid <= 1'b0;
    end else if (launch) begin
      bcnt_q    <= '0;
      out_byte  <= frame_in[FRAME_W-1 -: BYTE_W];
      out_sof   <= 1'b1;
      out_valid <= 1'b1;
    end else begin
      bcnt_q    <= bcnt_q + BC_W'(1);
      out_byte  <= pay_q[PAY_W-1 -: BYTE_W] ^ ks;
      out_sof   <= 1'b0;
      scr_q     <= scr_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (launch) pay_q <= frame_in[PAY_W-1:0];
    else        pay_q <= pay_q << BYTE_W;
  end

  p_sof_single_r2: assert property (@(posedge clk) disable iff (rst)
    out_sof |=> !out_sof);
  p_valid_holds_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);
  p_sync_nibble_r3: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> (out_byte[BYTE_W-1 -: SYNC_W] == SYNC_VAL));
  p_scr_alive_r6: assert property (@(posedge clk) disable iff (rst)
    scr_q != '0);
  p_scr_hold_hdr_r6: assert property (@(posedge clk) disable iff (rst)
    launch |=> $stable(scr_q));
endmodule

// File: rtl/sp_frame_packer.sv
module sp_frame_packer
  import spf_pkg::*;
#(
  parameter int PKT_W  = 30,
  parameter int SLOTS  = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PKT_W-1:0]  in_data,
  output logic              in_ready,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_sof,
  output logic              out_valid
);
  localparam int HDR_W   = SYNC_W + SLOTS;
  localparam int FRAME_W = HDR_W + SLOTS * PKT_W;

  logic                   launch;
  logic [SLOTS*PKT_W-1:0] slots_flat;
  logic [FRAME_W-1:0]     frame;

  initial begin
    if (HDR_W != BYTE_W || (FRAME_W % BYTE_W) != 0)
      $error("frame geometry does not fit the byte width");
  end

  spf_slot_collector #(.PKT_W(PKT_W), .SLOTS(SLOTS)) i_collect (
    .clk(clk), .rst(rst), .launch(launch), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .slots_flat(slots_flat)
  );

  spf_frame_assembler #(.PKT_W(PKT_W), .SLOTS(SLOTS)) i_assemble (
    .slots_flat(slots_flat), .frame(frame)
  );

  spf_byte_serializer #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) i_ser (
    .clk(clk), .rst(rst), .frame_in(frame), .launch(launch),
    .out_byte(out_byte), .out_sof(out_sof), .out_valid(out_valid)
  );
endmodule

// File: tb/test_sp_frame_packer.sv
module test_sp_frame_packer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [29:0] in_data = '0;
  logic        in_ready;
  logic [7:0]  out_byte;
  logic        out_sof, out_valid;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [29:0]  mq[$];
  int           mbc;
  int           mscr;
  logic [119:0] mpay;
  logic [7:0]   e_byte;
  logic         e_sof, e_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_frame_packer i_sp_frame_packer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_byte(out_byte), .out_sof(out_sof),
    .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] keystream();
    logic [7:0] k;
    int fb;
    for (int i = 7; i >= 0; i--) begin
      fb = ((mscr >> 6) ^ (mscr >> 5)) & 1;
      k[i] = fb[0];
      mscr = ((mscr << 1) | fb) & 127;
    end
    return k;
  endfunction

  // one clock: check last prediction, drive offer, predict next edge
  task automatic step(input logic v, input logic [29:0] d);
    logic         rdy, take;
    logic [29:0]  pk;
    logic [3:0]   par;
    check(e_sof ? "R3/R4 header byte" : "R5/R6/R7 payload byte",
          32'(out_byte), 32'(e_byte));
    check("R2 sof", 32'(out_sof), 32'(e_sof));
    check("R2 valid", 32'(out_valid), 32'(e_valid));
    in_valid = v;
    in_data  = d;
    #1;
    rdy  = (mq.size() < 4) || (mbc == 15);
    take = v && rdy;
    check(mbc == 15 ? "R9 ready at launch" : "R8 ready", 32'(in_ready), 32'(rdy));
    if (mbc == 15) begin
      for (int k = 0; k < 4; k++) begin
        pk = (k < mq.size()) ? mq[k] : 30'd0;
        par[k] = ^pk;
        mpay[119 - 30*k -: 30] = pk;
      end
      e_byte  = {4'h5, par};
      e_sof   = 1'b1;
      e_valid = 1'b1;
      mbc     = 0;
      mq.delete();
    end else begin
      e_byte = mpay[119:112] ^ keystream();
      mpay   = mpay << 8;
      e_sof  = 1'b0;
      mbc++;
    end
    if (take) mq.push_back(d);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [29:0] cnt;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 byte", 32'(out_byte), 32'd0);
    check("R1 sof", 32'(out_sof), 32'd0);
    check("R1 valid", 32'(out_valid), 32'd0);
    rst     = 1'b0;
    mbc     = 15;
    mscr    = 127;
    mpay    = '0;
    e_byte  = '0;
    e_sof   = 1'b0;
    e_valid = 1'b0;
    // idle: empty slots, scrambled zero payload (R7, R6)
    for (int i = 0; i < 48; i++) step(1'b0, '0);
    // continuous offers: back-pressure when full (R8), launch-cycle take (R9)
    cnt = 30'd1;
    for (int i = 0; i < 200; i++) begin
      step(1'b1, cnt);
      if (in_ready) cnt = cnt + 30'd1;
    end
    // partial frames with n packets each (R5, R7)
    for (int n = 0; n <= 4; n++) begin
      for (int i = 0; i < 16; i++)
        step(i < n, {30{1'b1}} ^ 30'(i));
    end
    // single-bit and all-ones patterns for parity (R4)
    for (int i = 0; i < 96; i++)
      step(1'b1, (i % 2) ? 30'h3FFFFFFF : (30'd1 << (i % 30)));
    // random traffic
    for (int i = 0; i < 800; i++)
      step(($urandom % 3) != 0, 30'($urandom));
    step(1'b0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule